// File: doc/BRIEF.md
# Overhead-Slot HDLC Message Transmitter

This block sends one variable-length data-link message as an HDLC frame through a single overhead byte of an outgoing E3 frame stream. The host first fills an internal message buffer through a byte write port and sets the message length. It then raises a start request. The block opens the frame with a flag and sends the message bytes least-significant bit first. It inserts a zero after every run of five ones, appends a complemented CRC-16 check sequence and closes the frame with another flag. Between messages it keeps the slot filled with idle flags.

The bit stream does not run on a serial clock. The framer pulses a strobe for each overhead byte opportunity, one strobe for the network-requirement byte and one for the general-communication byte. A configuration input chooses which of the two carries the channel. Each strobe on the chosen byte releases exactly eight bits of the stream. A byte of the stream that straddles the end of one slot continues in the next slot, so frames are not byte-aligned to the slots. A busy flag, a sticky completion status that a status read clears, and a masked interrupt let software run one message at a time.

Top module: `ohdl_msg_tx`

## Requirements
- R1: Bytes written at addresses 0 to msg_len-1 (msg_len from 1 to 82) appear in the frame in address order, each byte sent bit 0 first.
- R2: A 0-to-1 change of start_req while busy is 0 sets busy on the next clock edge. Holding start_req at 1 after a message ends does not launch another message.
- R3: A 0-to-1 change of start_req while busy is 1 is ignored, so exactly one frame is sent.
- R4: Two check bytes follow the last message byte. They hold the complement of a CRC-16 (polynomial x^16+x^12+x^5+1, bit-reversed form 0x8408, preset 0xFFFF, data fed LSB first). The check bytes are sent LSB first, so a CRC taken over message plus check bytes leaves the remainder 0xF0B8.
- R5: After five consecutive 1s in the message or check bits, a 0 is inserted. Flag bits are never stuffed, so messages made of 0xFF or 0x7E bytes arrive intact.
- R6: Every frame opens and closes with the flag 0x7E. While idle the slot carries back-to-back flags, and after reset every emitted byte is 0x7E.
- R7: Each selected strobe emits one byte on slot_data, with slot_load high, one clock after the strobe. slot_data bit 0 is the earliest bit of the stream, and the stream continues unbroken across slots.
- R8: With nr_select at 1 only nr_stb releases bytes; with nr_select at 0 only gc_stb does. A strobe on the other byte produces no slot_load.
- R9: busy falls on the same clock edge on which the byte holding the last bit of the closing flag is emitted, and irq_status is set on that edge.
- R10: A stat_rd pulse clears irq_status on the next edge. A completion in the same cycle takes precedence.
- R11: irq equals irq_status AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_we | input | 1 | Message buffer write strobe |
| buf_addr | input | 7 | Message buffer byte address |
| buf_wdata | input | 8 | Message buffer write data |
| msg_len | input | 7 | Message length in bytes, 1 to 82 |
| start_req | input | 1 | Start request level; its rising edge launches a message |
| nr_select | input | 1 | 1 selects the NR byte strobe, 0 the GC byte strobe |
| irq_en | input | 1 | Interrupt enable |
| stat_rd | input | 1 | Status read pulse; clears irq_status |
| nr_stb | input | 1 | NR overhead byte opportunity from the framer |
| gc_stb | input | 1 | GC overhead byte opportunity from the framer |
| slot_data | output | 8 | Byte for the current overhead slot, bit 0 sent first |
| slot_load | output | 1 | slot_data valid for one cycle |
| busy | output | 1 | A message is pending or in flight |
| irq_status | output | 1 | Sticky message-complete status |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach from the ports is the one where stuffing and byte slots interact. A message of all-ones or flag-valued bytes adds stuffed zeros, so the check sequence and closing flag land at arbitrary bit offsets inside a slot. A run of ones may also end exactly where the check sequence meets the closing flag. The bench drives such messages at several lengths, including the 82-byte maximum, and collects every emitted slot byte into one continuous bit stream. It then decodes that stream with its own flag-hunting, destuffing receiver and checks the recovered bytes and the CRC remainder. A second start edge is injected mid-frame, and start is held high after completion, so the decoder must count exactly one frame.

// File: rtl/ohdl_pkg.sv
package ohdl_pkg;

    localparam int MAX_LEN_DEF = 82;
    localparam logic [7:0]  FLAG_BYTE = 8'h7E;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam int STUFF_RUN = 5;
    localparam int FCS_BITS = 16;

    typedef enum logic [1:0] {
        G_IDLE,
        G_DATA,
        G_FCS,
        G_CLOSE
    } gen_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       vld;
        logic       last;
    } slot_byte_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic [15:0] nxt;
        nxt = c >> 1;
        if (c[0] ^ b) nxt = nxt ^ CRC_POLY_REV;
        return nxt;
    endfunction

endpackage

// File: rtl/ohdl_msg_buf.sv
module ohdl_msg_buf #(
    parameter int DEPTH = 82,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
    end

    always_comb begin
        rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
    end
endmodule

// File: rtl/ohdl_bit_gen.sv
module ohdl_bit_gen
    import ohdl_pkg::*;
#(
    parameter int MAX_LEN = 82,
    parameter int AW      = 7,
    parameter int LW      = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [LW-1:0] len,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    input  logic          take,
    output logic          bit_val,
    output logic          bit_end,
    output logic          frame_start
);
    gen_state_e    st;
    logic [2:0]    bidx;
    logic [3:0]    fcnt;
    logic [2:0]    ones;
    logic [AW-1:0] byte_idx;
    logic [15:0]   crc;
    logic [15:0]   fcs_sh;
    logic          stuff;
    logic          last_byte;
    logic [15:0]   crc_nxt;
    int            len_eff;

    always_comb begin
        if (int'(len) == 0)            len_eff = 1;
        else if (int'(len) > MAX_LEN)  len_eff = MAX_LEN;
        else                           len_eff = int'(len);
    end

    assign rd_addr   = byte_idx;
    assign last_byte = (int'(byte_idx) == len_eff - 1);
    assign stuff     = (int'(ones) == STUFF_RUN) &&
                       ((st == G_DATA) || (st == G_FCS) || (st == G_CLOSE && bidx == 3'd0));

    always_comb begin
        if (stuff)                          bit_val = 1'b0;
        else if (st == G_DATA)              bit_val = rd_data[bidx];
        else if (st == G_FCS)               bit_val = fcs_sh[0];
        else                                bit_val = FLAG_BYTE[bidx];
    end

    assign crc_nxt     = crc_step(crc, bit_val);
    assign bit_end     = take && !stuff && (st == G_CLOSE) && (bidx == 3'd7);
    assign frame_start = take && (st == G_IDLE) && (bidx == 3'd7) && go;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= G_IDLE;
            bidx     <= '0;
            fcnt     <= '0;
            ones     <= '0;
            byte_idx <= '0;
            crc      <= CRC_PRESET;
            fcs_sh   <= '0;
        end else if (take) begin
            if (stuff) begin
                ones <= '0;
            end else begin
                unique case (st)
                    G_IDLE: begin
                        bidx <= bidx + 3'd1;
                        ones <= '0;
                        if (bidx == 3'd7 && go) begin
                            st       <= G_DATA;
                            byte_idx <= '0;
                            crc      <= CRC_PRESET;
                        end
                    end
                    G_DATA: begin
                        crc  <= crc_nxt;
                        ones <= bit_val ? ones + 3'd1 : 3'd0;
                        bidx <= bidx + 3'd1;
                        if (bidx == 3'd7) begin
                            if (last_byte) begin
                                st     <= G_FCS;
                                fcnt   <= '0;
                                fcs_sh <= ~crc_nxt;
                            end else begin
                                byte_idx <= byte_idx + 1'b1;
                            end
                        end
                    end
                    G_FCS: begin
                        fcs_sh <= fcs_sh >> 1;
                        ones   <= bit_val ? ones + 3'd1 : 3'd0;
                        fcnt   <= fcnt + 4'd1;
                        if (int'(fcnt) == FCS_BITS - 1) begin
                            st   <= G_CLOSE;
                            bidx <= '0;
                        end
                    end
                    default: begin
                        ones <= '0;
                        bidx <= bidx + 3'd1;
                        if (bidx == 3'd7) st <= G_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ohdl_slot_pack.sv
module ohdl_slot_pack
    import ohdl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stb,
    input  logic       bit_val,
    input  logic       bit_end,
    output logic       take,
    output logic       emit_end,
    output logic [7:0] slot_data,
    output logic       slot_load
);
    logic [7:0] asm_q;
    logic [3:0] asm_cnt;
    logic       asm_end;
    slot_byte_t rdy;
    logic       move;

    assign take     = (asm_cnt < 4'd8);
    assign move     = (asm_cnt == 4'd8) && (!rdy.vld || stb);
    assign emit_end = stb && rdy.vld && rdy.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            asm_q     <= '0;
            asm_cnt   <= '0;
            asm_end   <= 1'b0;
            rdy       <= '0;
            slot_data <= '0;
            slot_load <= 1'b0;
        end else begin
            slot_load <= stb;
            if (stb) slot_data <= rdy.data;

            if (move) begin
                rdy     <= '{data: asm_q, vld: 1'b1, last: asm_end};
                asm_cnt <= '0;
                asm_end <= 1'b0;
            end else begin
                if (stb) rdy.vld <= 1'b0;
                if (take) begin
                    asm_q   <= {bit_val, asm_q[7:1]};
                    asm_cnt <= asm_cnt + 4'd1;
                    asm_end <= asm_end | bit_end;
                end
            end
        end
    end
endmodule

// File: rtl/ohdl_msg_tx.sv
module ohdl_msg_tx
    import ohdl_pkg::*;
#(
    parameter  int MAX_LEN = MAX_LEN_DEF,
    localparam int AW      = $clog2(MAX_LEN),
    localparam int LW      = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_wdata,
    input  logic [LW-1:0] msg_len,
    input  logic          start_req,
    input  logic          nr_select,
    input  logic          irq_en,
    input  logic          stat_rd,
    input  logic          nr_stb,
    input  logic          gc_stb,
    output logic [7:0]    slot_data,
    output logic          slot_load,
    output logic          busy,
    output logic          irq_status,
    output logic          irq
);
    logic          start_q;
    logic          pend;
    logic          launch;
    logic          sel_stb;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          take;
    logic          bit_val;
    logic          bit_end;
    logic          frame_start;
    logic          emit_end;

    assign sel_stb = nr_select ? nr_stb : gc_stb;
    assign launch  = start_req && !start_q && !busy;

    ohdl_msg_buf #(.DEPTH(MAX_LEN), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_addr),
        .wdata (buf_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    ohdl_bit_gen #(.MAX_LEN(MAX_LEN), .AW(AW), .LW(LW)) u_gen (
        .clk         (clk),
        .rst         (rst),
        .go          (pend),
        .len         (msg_len),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .take        (take),
        .bit_val     (bit_val),
        .bit_end     (bit_end),
        .frame_start (frame_start)
    );

    ohdl_slot_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .stb       (sel_stb),
        .bit_val   (bit_val),
        .bit_end   (bit_end),
        .take      (take),
        .emit_end  (emit_end),
        .slot_data (slot_data),
        .slot_load (slot_load)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q    <= 1'b0;
            busy       <= 1'b0;
            pend       <= 1'b0;
            irq_status <= 1'b0;
        end else begin
            start_q <= start_req;
            if (launch) begin
                busy <= 1'b1;
                pend <= 1'b1;
            end else begin
                if (frame_start) pend <= 1'b0;
                if (emit_end)    busy <= 1'b0;
            end
            if (emit_end)     irq_status <= 1'b1;
            else if (stat_rd) irq_status <= 1'b0;
        end
    end

    assign irq = irq_status & irq_en;
endmodule

// File: rtl/ohdl_msg_tx_chk.sv
module ohdl_msg_tx_chk (
    input logic clk,
    input logic rst,
    input logic nr_select,
    input logic nr_stb,
    input logic gc_stb,
    input logic start_req,
    input logic stat_rd,
    input logic irq_en,
    input logic busy,
    input logic slot_load,
    input logic irq_status,
    input logic irq
);
    assert_launch_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(start_req) && !busy) |=> busy);

    assert_load_from_selected_R8: assert property (@(posedge clk) disable iff (rst)
        slot_load |-> $past(nr_select ? nr_stb : gc_stb));

    assert_done_on_emit_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (slot_load && irq_status));

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !busy) |=> !irq_status);

    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);
endmodule

bind ohdl_msg_tx ohdl_msg_tx_chk u_chk (.*);

// File: tb/ohdl_msg_tx_test.sv
module ohdl_msg_tx_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       buf_we = 1'b0;
    logic [6:0] buf_addr = '0;
    logic [7:0] buf_wdata = '0;
    logic [6:0] msg_len = 7'd1;
    logic       start_req = 1'b0;
    logic       nr_select = 1'b1;
    logic       irq_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic       nr_stb = 1'b0;
    logic       gc_stb = 1'b0;
    logic [7:0] slot_data;
    logic       slot_load;
    logic       busy;
    logic       irq_status;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit rx_bits[$];
    int nframes;
    int fr_len;
    logic [7:0] fr_bytes [128];

    // columns: length, data pattern, nr_select, irq_en, mid-frame restart
    localparam int NVEC = 6;
    localparam int VEC [NVEC][5] = '{
        '{1,  0, 1, 1, 0},
        '{5,  1, 0, 1, 0},
        '{16, 2, 1, 0, 0},
        '{33, 3, 0, 1, 1},
        '{82, 1, 1, 1, 0},
        '{2,  2, 0, 0, 1}
    };

    always #2 clk = ~clk;

    ohdl_msg_tx uut (.*);

    always @(negedge clk) begin
        if (slot_load) begin
            for (int b = 0; b < 8; b++) rx_bits.push_back(slot_data[b]);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        if (seed == 1) return 8'hFF;
        if (seed == 2) return 8'h7E;
        return 8'((i * 37 + seed * 11 + 3) & 255);
    endfunction

    function automatic logic [15:0] crc_over(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ fr_bytes[k][b];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    task automatic decode();
        int ones = 0;
        bit acc[$];
        nframes = 0;
        fr_len = 0;
        foreach (rx_bits[k]) begin
            if (rx_bits[k]) begin
                acc.push_back(1'b1);
                ones++;
            end else if (ones == 5) begin
                ones = 0;
            end else if (ones == 6) begin
                for (int r = 0; r < 7; r++) if (acc.size() > 0) void'(acc.pop_back());
                if (acc.size() >= 24 && acc.size() % 8 == 0 && acc.size() <= 1024) begin
                    nframes++;
                    fr_len = acc.size() / 8;
                    for (int j = 0; j < fr_len; j++)
                        for (int b = 0; b < 8; b++) fr_bytes[j][b] = acc[j * 8 + b];
                end
                acc.delete();
                ones = 0;
            end else begin
                acc.push_back(1'b0);
                ones = 0;
            end
        end
    endtask

    task automatic slot_pulse(input bit nr);
        @(negedge clk);
        if (nr) nr_stb = 1'b1; else gc_stb = 1'b1;
        @(negedge clk);
        nr_stb = 1'b0; gc_stb = 1'b0;
        chk(slot_load == 1'b1, "R7 load after selected strobe", int'(slot_load), 1);
        repeat (6) @(negedge clk);
        if (nr) gc_stb = 1'b1; else nr_stb = 1'b1;
        @(negedge clk);
        nr_stb = 1'b0; gc_stb = 1'b0;
        chk(slot_load == 1'b0, "R8 other strobe ignored", int'(slot_load), 0);
        repeat (7) @(negedge clk);
    endtask

    task automatic run_msg(input int len, input int seed, input bit nr, input bit ien, input bit retrig);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            buf_we = 1'b1; buf_addr = 7'(i); buf_wdata = pat(seed, i);
        end
        @(negedge clk);
        buf_we = 1'b0;
        msg_len = 7'(len); nr_select = nr; irq_en = ien;
        rx_bits.delete();
        start_req = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after start edge", int'(busy), 1);
        for (int s = 0; s < 400 && busy; s++) begin
            slot_pulse(nr);
            if (retrig && s == 3) begin
                @(negedge clk); start_req = 1'b0;
                @(negedge clk); start_req = 1'b1;
            end
        end
        chk(busy == 1'b0, "R9 busy cleared", int'(busy), 0);
        chk(irq_status == 1'b1, "R9 status set at end", int'(irq_status), 1);
        chk(irq == ien, "R11 irq equals status and enable", int'(irq), int'(ien));
        for (int s = 0; s < 6; s++) slot_pulse(nr);
        chk(busy == 1'b0, "R2 held start no relaunch", int'(busy), 0);
        decode();
        chk(nframes == 1, retrig ? "R3 restart while busy ignored" : "R2 one frame per start", nframes, 1);
        chk(fr_len == len + 2, "R1 frame length", fr_len, len + 2);
        for (int i = 0; i < len && i < fr_len; i++)
            chk(fr_bytes[i] == pat(seed, i), seed != 0 ? "R5 stuffed byte intact" : "R1 message byte",
                int'(fr_bytes[i]), int'(pat(seed, i)));
        chk(crc_over(fr_len) == 16'hF0B8, "R4 check sequence remainder", int'(crc_over(fr_len)), 'hF0B8);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        chk(irq_status == 1'b0, "R10 read clears status", int'(irq_status), 0);
        chk(irq == 1'b0, "R11 irq low after read", int'(irq), 0);
        start_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy low after reset", int'(busy), 0);
        chk(irq_status == 1'b0, "R10 status low after reset", int'(irq_status), 0);
        chk(slot_load == 1'b0, "R7 no load after reset", int'(slot_load), 0);
        repeat (20) @(negedge clk);
        rx_bits.delete();
        for (int s = 0; s < 3; s++) slot_pulse(1'b1);
        for (int s = 0; s < 3; s++) begin
            logic [7:0] got;
            for (int b = 0; b < 8; b++) got[b] = rx_bits[s * 8 + b];
            chk(got == 8'h7E, "R6 idle flag byte", int'(got), 'h7E);
        end

        for (int v = 0; v < NVEC; v++)
            run_msg(VEC[v][0], VEC[v][1], VEC[v][2] != 0, VEC[v][3] != 0, VEC[v][4] != 0);

        // R10: a completion coinciding with a read leaves the status set
        irq_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); buf_we = 1'b1; buf_addr = 7'(i); buf_wdata = 8'hA5;
        end
        @(negedge clk); buf_we = 1'b0; msg_len = 7'd3; nr_select = 1'b1; start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        for (int s = 0; s < 100 && busy; s++) begin
            @(negedge clk); nr_stb = 1'b1; stat_rd = 1'b1;
            @(negedge clk); nr_stb = 1'b0; stat_rd = 1'b0;
            repeat (14) @(negedge clk);
        end
        chk(irq_status == 1'b1, "R10 completion wins over read", int'(irq_status), 1);
        chk(irq == 1'b1, "R11 irq high with enable", int'(irq), 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule